// File: doc/BRIEF.md
# Return-From-Exception Status Unstacker

This block restores processor status when a return-from-exception or a return-from-non-maskable-interrupt instruction retires. On the strobe it takes the current 32-bit status word, keeps its two most significant bits, and moves the low mode field right by ten positions, so the mode bits that exception entry had stacked higher in the word come back into place. The P flag is then forced on unless the R flag was set in the word before the shift. The non-maskable-interrupt variant also forces the M flag on.

When the restored word indicates user mode (the U flag set after the shift), the stack pointers are exchanged. The incoming stack pointer is kept as the saved kernel stack pointer, and the stack pointer output takes the user stack pointer. All three results are registered. They change on one clock edge when a strobe is high and hold otherwise. The pipeline feeds the registered values back into its register file.

Top module: `rfe_unstacker`

## Requirements
- R1: While `rst` is high at a clock edge, `status_q`, `sp_q` and `ksp_q` are all cleared to zero.
- R2: One clock edge after a strobe, `status_q[29:0]` equals `status_in[27:0]` shifted right by 10, zero-filled, apart from the P and M adjustments. Bits 29..18 come out zero and bits 17..0 take `status_in[27:10]`.
- R3: One clock edge after `rfe_strobe` alone, `status_q[31:30]` equals `status_in[31:30]`.
- R4: After either strobe, P (`status_q[7]`) is 1 when the pre-shift R flag (`status_in[8]`) was 0. Otherwise P is the shifted bit, `status_in[17]`.
- R5: One clock edge after `rfn_strobe`, M (`status_q[30]`) is 1. `status_q[31]` still equals `status_in[31]`.
- R6: When a strobe is high and the shifted word has U set (`status_in[18]`, which lands at bit 8), `ksp_q` takes `sp_in` and `sp_q` takes `usp_in` at the next edge.
- R7: When a strobe is high and the shifted U is 0, `sp_q` takes `sp_in` and `ksp_q` keeps its previous value.
- R8: With neither strobe high, `status_q`, `sp_q` and `ksp_q` keep their values whatever the data inputs carry.
- R9: With both strobes high together, the result is the same as for `rfn_strobe` alone. M is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfe_strobe | input | 1 | Return-from-exception instruction retires |
| rfn_strobe | input | 1 | Return-from-NMI instruction retires |
| status_in | input | 32 | Current status word, before unstacking |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | User stack pointer |
| status_q | output | 32 | Unstacked status word |
| sp_q | output | 32 | Next stack pointer |
| ksp_q | output | 32 | Saved kernel stack pointer |

## Verification
The hardest cases are where the pre-shift R flag and the stacked U flag interact with the bits that land on P, and with the hold behaviour of the kernel stack pointer across a non-user return. These are easy to miss because R and the shifted U share bit position 8 in different words. The stimulus sweeps every combination of bits 31, 30, 29, 18, 17 and 8 under each of the three strobe patterns. This covers P set by the R rule versus P carried from bit 17, and it exercises U swaps against non-swaps in every order. Hold cycles with changed data inputs are inserted between returns, so a kernel pointer that is wrongly overwritten shows up at the following check.

// File: rtl/rfe_pkg.sv
`timescale 1ns/1ps
package rfe_pkg;

  typedef enum logic [1:0] {
    RET_NONE = 2'd0,
    RET_EXC  = 2'd1,
    RET_NMI  = 2'd2
  } ret_kind_e;

endpackage

// File: rtl/rfe_ret_decode.sv
`timescale 1ns/1ps
module rfe_ret_decode
  import rfe_pkg::*;
(
  input  logic      exc_strobe,
  input  logic      nmi_strobe,
  output ret_kind_e kind
);

  // The NMI variant wins when both strobes arrive together.
  always_comb begin
    if (nmi_strobe)      kind = RET_NMI;
    else if (exc_strobe) kind = RET_EXC;
    else                 kind = RET_NONE;
  end

endmodule

// File: rtl/rfe_status_unstack.sv
`timescale 1ns/1ps
module rfe_status_unstack #(
  parameter int DATA_W  = 32,
  parameter int KEEP_HI = 2,
  parameter int FIELD_W = 28,
  parameter int SHIFT   = 10,
  parameter int U_BIT   = 8,
  parameter int P_BIT   = 7,
  parameter int M_BIT   = 30,
  parameter int R_BIT   = 8
) (
  input  logic [DATA_W-1:0] status_in,
  input  logic              is_nmi,
  output logic [DATA_W-1:0] status_out,
  output logic              user_mode
);

  localparam logic [DATA_W-1:0] ONES       = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] KEEP_MASK  = ~(ONES >> KEEP_HI);
  localparam logic [DATA_W-1:0] FIELD_MASK = ONES >> (DATA_W - FIELD_W);

  logic [DATA_W-1:0] shifted;
  logic              r_before;

  always_comb begin
    shifted   = (status_in & KEEP_MASK) | ((status_in & FIELD_MASK) >> SHIFT);
    r_before  = status_in[R_BIT];
    user_mode = shifted[U_BIT];
    status_out = shifted;
    if (!r_before) status_out[P_BIT] = 1'b1;
    if (is_nmi)    status_out[M_BIT] = 1'b1;
  end

endmodule

// File: rtl/rfe_stack_swap.sv
`timescale 1ns/1ps
module rfe_stack_swap #(
  parameter int ADDR_W = 32
) (
  input  logic              user_mode,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] usp_in,
  input  logic [ADDR_W-1:0] ksp_cur,
  output logic [ADDR_W-1:0] sp_next,
  output logic [ADDR_W-1:0] ksp_next
);

  always_comb begin
    if (user_mode) begin
      ksp_next = sp_in;
      sp_next  = usp_in;
    end else begin
      ksp_next = ksp_cur;
      sp_next  = sp_in;
    end
  end

endmodule

// File: rtl/rfe_unstacker.sv
`timescale 1ns/1ps
module rfe_unstacker
  import rfe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int KEEP_HI = 2,
  parameter int FIELD_W = 28,
  parameter int SHIFT   = 10,
  parameter int U_BIT   = 8,
  parameter int P_BIT   = 7,
  parameter int M_BIT   = 30,
  parameter int R_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rfe_strobe,
  input  logic              rfn_strobe,
  input  logic [DATA_W-1:0] status_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] usp_in,
  output logic [DATA_W-1:0] status_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] ksp_q
);

  localparam int U_SRC = U_BIT + SHIFT;

  ret_kind_e         kind;
  logic [DATA_W-1:0] status_nx;
  logic              user_mode;
  logic [ADDR_W-1:0] sp_nx;
  logic [ADDR_W-1:0] ksp_nx;

  rfe_ret_decode u_decode (
    .exc_strobe (rfe_strobe),
    .nmi_strobe (rfn_strobe),
    .kind       (kind)
  );

  rfe_status_unstack #(
    .DATA_W  (DATA_W),
    .KEEP_HI (KEEP_HI),
    .FIELD_W (FIELD_W),
    .SHIFT   (SHIFT),
    .U_BIT   (U_BIT),
    .P_BIT   (P_BIT),
    .M_BIT   (M_BIT),
    .R_BIT   (R_BIT)
  ) u_unstack (
    .status_in  (status_in),
    .is_nmi     (kind == RET_NMI),
    .status_out (status_nx),
    .user_mode  (user_mode)
  );

  rfe_stack_swap #(
    .ADDR_W (ADDR_W)
  ) u_swap (
    .user_mode (user_mode),
    .sp_in     (sp_in),
    .usp_in    (usp_in),
    .ksp_cur   (ksp_q),
    .sp_next   (sp_nx),
    .ksp_next  (ksp_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      sp_q     <= '0;
      ksp_q    <= '0;
    end else if (kind != RET_NONE) begin
      status_q <= status_nx;
      sp_q     <= sp_nx;
      ksp_q    <= ksp_nx;
    end
  end

  // R8: idle cycles leave every register untouched
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!rfe_strobe && !rfn_strobe) |=> ($stable(status_q) && $stable(sp_q) && $stable(ksp_q)));

  // R3: the kept high bits survive an exception return
  p_keep_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (rfe_strobe && !rfn_strobe) |=> (status_q[DATA_W-1 -: KEEP_HI] == $past(status_in[DATA_W-1 -: KEEP_HI])));

  // R4: a clear R flag before the shift forces P
  p_p_forced_r4: assert property (@(posedge clk) disable iff (rst)
    ((rfe_strobe || rfn_strobe) && !status_in[R_BIT]) |=> status_q[P_BIT]);

  // R5 and R9: any NMI return leaves M set
  p_m_set_r5: assert property (@(posedge clk) disable iff (rst)
    rfn_strobe |=> status_q[M_BIT]);

  // R6: returning to user mode swaps the stack pointers
  p_swap_r6: assert property (@(posedge clk) disable iff (rst)
    ((rfe_strobe || rfn_strobe) && status_in[U_SRC]) |=> ((ksp_q == $past(sp_in)) && (sp_q == $past(usp_in))));

  // R7: a non-user return keeps the kernel pointer
  p_noswap_r7: assert property (@(posedge clk) disable iff (rst)
    ((rfe_strobe || rfn_strobe) && !status_in[U_SRC]) |=> ($stable(ksp_q) && (sp_q == $past(sp_in))));

endmodule

// File: tb/tb_rfe_unstacker.sv
`timescale 1ns/1ps
module tb_rfe_unstacker;

  logic        clk = 1'b0;
  logic        rst;
  logic        rfe_strobe;
  logic        rfn_strobe;
  logic [31:0] status_in;
  logic [31:0] sp_in;
  logic [31:0] usp_in;
  logic [31:0] status_q;
  logic [31:0] sp_q;
  logic [31:0] ksp_q;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] exp_st  = '0;
  logic [31:0] exp_sp  = '0;
  logic [31:0] exp_ksp = '0;

  always #4 clk = ~clk;

  rfe_unstacker dut (
    .clk        (clk),
    .rst        (rst),
    .rfe_strobe (rfe_strobe),
    .rfn_strobe (rfn_strobe),
    .status_in  (status_in),
    .sp_in      (sp_in),
    .usp_in     (usp_in),
    .status_q   (status_q),
    .sp_q       (sp_q),
    .ksp_q      (ksp_q)
  );

  function automatic logic [31:0] model(input logic [31:0] s, input logic nmi);
    logic [31:0] r;
    r = {s[31:30], 2'b00, 10'd0, s[27:10]};
    if (!s[8]) r[7] = 1'b1;
    if (nmi)   r[30] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] s, input logic [31:0] sp, input logic [31:0] usp,
                       input logic e, input logic n);
    string tag;
    @(negedge clk);
    status_in  = s;
    sp_in      = sp;
    usp_in     = usp;
    rfe_strobe = e;
    rfn_strobe = n;
    if (e || n) begin
      exp_st = model(s, n);
      if (exp_st[8]) begin
        exp_ksp = sp;
        exp_sp  = usp;
      end else begin
        exp_sp = sp;
      end
    end
    @(negedge clk);
    rfe_strobe = 1'b0;
    rfn_strobe = 1'b0;
    if (!e && !n)     tag = "R8 hold";
    else if (e && n)  tag = "R9 both strobes";
    else if (n)       tag = "R5 nmi return";
    else              tag = "R2 R3 R4 exc return";
    chk({tag, " status"}, status_q, exp_st);
    chk((e || n) ? (exp_st[8] ? "R6 sp" : "R7 sp") : "R8 sp", sp_q, exp_sp);
    chk((e || n) ? (exp_st[8] ? "R6 ksp" : "R7 ksp") : "R8 ksp", ksp_q, exp_ksp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1'b1;
    rfe_strobe = 1'b0;
    rfn_strobe = 1'b0;
    status_in = 32'hFFFF_FFFF;
    sp_in = 32'h1111_1111;
    usp_in = 32'h2222_2222;
    repeat (3) @(negedge clk);
    chk("R1 status", status_q, 32'h0);
    chk("R1 sp", sp_q, 32'h0);
    chk("R1 ksp", ksp_q, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < 64; c++) begin
        logic [31:0] s;
        s = 32'h0A5A_5A5A ^ (32'(c) * 32'h0101_0037);
        s[31] = c[5];
        s[30] = c[4];
        s[29] = c[3];
        s[18] = c[2];
        s[17] = c[1];
        s[8]  = c[0];
        apply(s, 32'h8000_0000 + 32'(c * 16 + k), 32'h4000_0000 + 32'(c * 32 + k),
              (k != 1), (k != 0));
        if (c % 8 == 7)
          apply(~s, 32'hDEAD_0000 + 32'(c), 32'hBEEF_0000 + 32'(c), 1'b0, 1'b0);
      end
    end

    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr, lfsr ^ 32'h5555_AAAA, ~lfsr, lfsr[3], lfsr[5] & lfsr[9]);
    end

    apply(32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFE, 1'b1, 1'b0);
    apply(32'h0000_0000, 32'h0000_0003, 32'h0000_0004, 1'b1, 1'b0);
    apply(32'h0000_0000, 32'h0000_0005, 32'h0000_0006, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule